// File: doc/BRIEF.md
# Fuzzy Input Acquisition Port

This block takes 8-bit input variables for a fuzzy processor during its on-line phase, from a host or an A/D converter. It holds them in a bank of input registers. Each transfer uses a strobe/ready handshake. The source presents a byte, asserts the strobe, and gets a ready pulse one clock after the byte is captured. A new transfer is accepted only after the strobe has gone inactive again.

The block has two ways of choosing the destination register:
- In sequential mode it walks an internal index from 0 up to the configured count of active inputs, then wraps.
- In slave mode the host names the destination with a 3-bit select that is sampled along with the strobe. Inputs can then arrive in any order.

In both modes the block publishes the index of the input it expects next, so external logic can steer the right source onto the bus. When the host flags a transfer as the last one, the block issues a one-clock start pulse to the processing stage and rewinds the index to zero. Registers that are not written keep their value, so slowly changing inputs cost no transfer time. The strobe, ready and last-input signals each have a programmable polarity. While the download (off-line) mode input is high, no transfer is taken.

Top module: `fz_in_port`

## Requirements
- R1: After reset every input register reads 0, the next-input index is 0, ready is at its inactive level and the start pulse is low.
- R2: A strobe that was inactive on the previous clock and is active on this clock is accepted. The byte on the data bus is stored, and after that same edge ready shows its active level for exactly one clock.
- R3: A strobe held active is accepted only once, and data changes during the hold are not stored. A further transfer needs the strobe to go inactive first.
- R4: In sequential mode (slave select 0) the destination is the current next-input index. After each accepted non-last transfer the index becomes index+1, or 0 when index+1 is at least the configured active count.
- R5: In slave mode (slave select 1) the 3-bit select picks the destination register. After a non-last transfer the next-input index becomes select+1, or 0 when select+1 is at least the active count.
- R6: A transfer accepted while last-input is active drives the start output high for exactly one clock, in the same clock as the ready pulse. It also sets the next-input index to 0.
- R7: Registers that are not the destination of an accepted transfer keep their stored value.
- R8: Each polarity select (strobe, ready, last-input) at 1 makes its signal active high; at 0 it makes the signal active low.
- R9: While the off-line input is high, no transfer is accepted: no ready, no start, and no register or index change. A strobe still held when off-line falls is not accepted until it has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offline_i | input | 1 | High during download; blocks acquisition |
| slave_i | input | 1 | 1 = destination from select, 0 = sequential |
| cfg_count_i | input | CNT_W | Number of active inputs (index wrap point) |
| strobe_pol_i | input | 1 | Strobe polarity, 1 = active high |
| ready_pol_i | input | 1 | Ready polarity, 1 = active high |
| last_pol_i | input | 1 | Last-input polarity, 1 = active high |
| strobe_i | input | 1 | Data-valid strobe from the source |
| sel_i | input | ID_W | Destination register in slave mode |
| data_i | input | DATA_W | Input variable byte |
| last_i | input | 1 | Flags the final input of a cycle |
| ready_o | output | 1 | One-clock capture acknowledge |
| start_o | output | 1 | One-clock start-of-processing pulse |
| next_id_o | output | ID_W | Index of the next input expected |
| in_vars_o | output | NUM_IN*DATA_W | Register bank, register k at bits k*DATA_W upward |

## Verification
The bench builds the block at its defaults: eight 8-bit registers and a 3-bit select. It configures five active inputs, which leaves registers 5 to 7 outside the sequential walk. Slave writes to register 6 and register 7 then show that the index wraps past the active count and that those registers still hold data. Sequential writes show the wrap from 4 back to 0. The polarity inputs are switched to active low mid-run, with the strobe moved to its new idle level in the same clock, to show that the inverted handshake works end to end.

// File: rtl/fz_in_pkg.sv
package fz_in_pkg;

  // Map between an active/inactive meaning and a pin level for a polarity bit.
  // pol = 1 means active high; the mapping is its own inverse.
  function automatic logic pol_map(input logic v, input logic pol);
    return v ~^ pol;
  endfunction

  // Index that follows cur when count registers are in use (wraps to zero).
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned count);
    return ((cur + 1) >= count) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/fz_in_hs.sv
module fz_in_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic offline_i,
  input  logic strobe_act_i,
  input  logic last_act_i,
  output logic accept_o,
  output logic ready_q_o,
  output logic start_q_o
);
  logic strobe_q;

  // Accept on the clock the strobe becomes active, outside download mode.
  assign accept_o = strobe_act_i & ~strobe_q & ~offline_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      ready_q_o <= 1'b0;
      start_q_o <= 1'b0;
    end else begin
      strobe_q  <= strobe_act_i;
      ready_q_o <= accept_o;
      start_q_o <= accept_o & last_act_i;
    end
  end

  p_ready_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q_o |=> !ready_q_o);

  p_held_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);

  p_start_with_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q_o |-> ready_q_o);

endmodule

// File: rtl/fz_in_seq.sv
module fz_in_seq #(
  parameter int NUM_IN = 8,
  parameter int ID_W   = 3,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             slave_i,
  input  logic             last_act_i,
  input  logic [ID_W-1:0]  sel_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  output logic [ID_W-1:0]  dst_o,
  output logic [ID_W-1:0]  next_o
);
  import fz_in_pkg::*;

  logic [ID_W-1:0] next_q;
  logic [ID_W-1:0] follow;

  assign dst_o  = slave_i ? sel_i : next_q;
  assign follow = ID_W'(next_index(int'(dst_o), int'(cfg_count_i)));
  assign next_o = next_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        next_q <= '0;
    else if (accept_i) next_q <= last_act_i ? '0 : follow;
  end

  p_next_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !last_act_i && cfg_count_i != 0 && cfg_count_i <= CNT_W'(NUM_IN))
      |=> ({1'b0, next_o} < $past(cfg_count_i)));

endmodule

// File: rtl/fz_in_bank.sv
module fz_in_bank #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [ID_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_IN*DATA_W-1:0] bank_o
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              val_q <= '0;
      else if (wr_i && addr_i == ID_W'(g))     val_q <= data_i;
    end
    assign bank_o[g*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/fz_in_port.sv
module fz_in_port #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  localparam int ID_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = ID_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     offline_i,
  input  logic                     slave_i,
  input  logic [CNT_W-1:0]         cfg_count_i,
  input  logic                     strobe_pol_i,
  input  logic                     ready_pol_i,
  input  logic                     last_pol_i,
  input  logic                     strobe_i,
  input  logic [ID_W-1:0]          sel_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     last_i,
  output logic                     ready_o,
  output logic                     start_o,
  output logic [ID_W-1:0]          next_id_o,
  output logic [NUM_IN*DATA_W-1:0] in_vars_o
);
  import fz_in_pkg::*;

  // Named internal events, visible to the assertions.
  logic            strobe_act;
  logic            last_act;
  logic            accept;
  logic            ready_q;
  logic            start_q;
  logic [ID_W-1:0] dst;

  assign strobe_act = pol_map(strobe_i, strobe_pol_i);
  assign last_act   = pol_map(last_i, last_pol_i);

  fz_in_hs u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .offline_i    (offline_i),
    .strobe_act_i (strobe_act),
    .last_act_i   (last_act),
    .accept_o     (accept),
    .ready_q_o    (ready_q),
    .start_q_o    (start_q)
  );

  fz_in_seq #(.NUM_IN(NUM_IN), .ID_W(ID_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .slave_i     (slave_i),
    .last_act_i  (last_act),
    .sel_i       (sel_i),
    .cfg_count_i (cfg_count_i),
    .dst_o       (dst),
    .next_o      (next_id_o)
  );

  fz_in_bank #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .ID_W(ID_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (accept),
    .addr_i (dst),
    .data_i (data_i),
    .bank_o (in_vars_o)
  );

  assign ready_o = pol_map(ready_q, ready_pol_i);
  assign start_o = start_q;

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> $stable(in_vars_o));

  p_offline_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    offline_i |=> !ready_q);

  p_start_rewinds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (next_id_o == '0));

  p_next_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> $stable(next_id_o));

endmodule

// File: tb/fz_in_port_tb_top.sv
`timescale 1ns/1ps
module fz_in_port_tb_top;
  localparam int NUM_IN = 8;
  localparam int DATA_W = 8;
  localparam int ID_W   = 3;
  localparam int CNT_W  = 4;
  localparam int NV     = 10;

  // Vector fields: slave, sel, data, last, expected dst, expected next, expected start
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h11, 1'b0, 3'd0, 3'd1, 1'b0},
    {1'b0, 3'd0, 8'h22, 1'b0, 3'd1, 3'd2, 1'b0},
    {1'b0, 3'd0, 8'h33, 1'b0, 3'd2, 3'd3, 1'b0},
    {1'b0, 3'd0, 8'h44, 1'b0, 3'd3, 3'd4, 1'b0},
    {1'b0, 3'd0, 8'h55, 1'b0, 3'd4, 3'd0, 1'b0},
    {1'b0, 3'd0, 8'h66, 1'b0, 3'd0, 3'd1, 1'b0},
    {1'b1, 3'd6, 8'h77, 1'b0, 3'd6, 3'd0, 1'b0},
    {1'b1, 3'd2, 8'h88, 1'b0, 3'd2, 3'd3, 1'b0},
    {1'b0, 3'd0, 8'hA5, 1'b1, 3'd3, 3'd0, 1'b1},
    {1'b1, 3'd7, 8'h5A, 1'b0, 3'd7, 3'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offline = 1'b0, slave = 1'b0;
  logic [CNT_W-1:0] cfg_count = 4'd5;
  logic spol = 1'b1, rpol = 1'b1, lpol = 1'b1;
  logic strobe = 1'b0, last = 1'b0;
  logic [ID_W-1:0] sel = '0;
  logic [DATA_W-1:0] data = '0;
  logic ready, start;
  logic [ID_W-1:0] next_id;
  logic [NUM_IN*DATA_W-1:0] in_vars;

  logic [DATA_W-1:0] mdl [NUM_IN];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fz_in_port dut_i (
    .clk(clk), .rst_n(rst_n), .offline_i(offline), .slave_i(slave),
    .cfg_count_i(cfg_count), .strobe_pol_i(spol), .ready_pol_i(rpol),
    .last_pol_i(lpol), .strobe_i(strobe), .sel_i(sel), .data_i(data),
    .last_i(last), .ready_o(ready), .start_o(start), .next_id_o(next_id),
    .in_vars_o(in_vars)
  );

  function automatic logic lvl(input bit act, input logic pol);
    return pol ? logic'(act) : logic'(!act);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NUM_IN; i++)
      chk(req, 64'(in_vars[i*DATA_W +: DATA_W]), 64'(mdl[i]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_IN; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(ready), 64'(lvl(0, rpol)));
    chk("R1 start", 64'(start), 64'd0);
    chk("R1 next", 64'(next_id), 64'd0);
    check_bank("R1 bank");

    // Table walk: R2, R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      e = VEC[v];
      slave = e[19]; sel = e[18:16]; data = e[15:8];
      last = lvl(e[7], lpol); strobe = lvl(1, spol);
      @(negedge clk);
      chk("R2 ready active", 64'(ready), 64'(lvl(1, rpol)));
      chk("R6 start", 64'(start), 64'(e[0]));
      mdl[e[6:4]] = e[15:8];
      check_bank("R7 bank");
      chk(e[19] ? "R5 next" : "R4 next", 64'(next_id), 64'(e[3:1]));
      @(negedge clk);
      chk("R2 ready one clock", 64'(ready), 64'(lvl(0, rpol)));
      chk("R6 start one clock", 64'(start), 64'd0);
      strobe = lvl(0, spol); last = lvl(0, lpol);
      @(negedge clk);
    end

    // R3: held strobe, data changes while held
    slave = 1'b0; data = 8'h3C; strobe = lvl(1, spol);
    @(negedge clk);
    mdl[0] = 8'h3C;
    chk("R3 first ready", 64'(ready), 64'(lvl(1, rpol)));
    data = 8'hC3;
    @(negedge clk);
    chk("R3 held no ready", 64'(ready), 64'(lvl(0, rpol)));
    @(negedge clk);
    chk("R3 held no ready 2", 64'(ready), 64'(lvl(0, rpol)));
    check_bank("R3 bank");
    chk("R3 next", 64'(next_id), 64'd1);
    strobe = lvl(0, spol);
    @(negedge clk);
    data = 8'h05; strobe = lvl(1, spol);
    @(negedge clk);
    mdl[1] = 8'h05;
    chk("R3 after release", 64'(ready), 64'(lvl(1, rpol)));
    check_bank("R3 bank 2");
    chk("R3 next 2", 64'(next_id), 64'd2);
    strobe = lvl(0, spol);
    @(negedge clk);

    // R8: all polarities active low; idle levels move together
    spol = 1'b0; rpol = 1'b0; lpol = 1'b0; strobe = 1'b1; last = 1'b1;
    @(negedge clk);
    chk("R8 ready idle high", 64'(ready), 64'd1);
    chk("R8 no spurious start", 64'(start), 64'd0);
    data = 8'h96; strobe = 1'b0; last = 1'b0;
    @(negedge clk);
    mdl[2] = 8'h96;
    chk("R8 ready low", 64'(ready), 64'd0);
    chk("R8 start", 64'(start), 64'd1);
    chk("R8 next", 64'(next_id), 64'd0);
    check_bank("R8 bank");
    @(negedge clk);
    chk("R8 ready back high", 64'(ready), 64'd1);
    strobe = 1'b1; last = 1'b1;
    @(negedge clk);
    spol = 1'b1; rpol = 1'b1; lpol = 1'b1; strobe = 1'b0; last = 1'b0;
    @(negedge clk);

    // R9: off-line blocks acquisition
    offline = 1'b1; data = 8'hFF; last = 1'b1; strobe = 1'b1;
    @(negedge clk);
    chk("R9 no ready", 64'(ready), 64'd0);
    chk("R9 no start", 64'(start), 64'd0);
    @(negedge clk);
    check_bank("R9 bank");
    chk("R9 next", 64'(next_id), 64'd0);
    offline = 1'b0;
    @(negedge clk);
    chk("R9 held after offline", 64'(ready), 64'd0);
    chk("R9 held no start", 64'(start), 64'd0);
    check_bank("R9 bank 2");
    strobe = 1'b0; last = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule